// File: doc/BRIEF.md
# Flash Region Lock and Security Manager

This block sits in front of a flash array that is split into sixteen protection regions of thirty-two pages each. It decodes single-strobe commands carrying an opcode, a small argument and a page address. Page program, page erase and whole-array erase requests are passed to the flash engine through a one-cycle start pulse. Before any of them is forwarded, the block checks the lock bit of the region being addressed. A request aimed at a locked region is dropped, and a lock-error flag and an optional interrupt are raised instead.

The block also keeps a security bit that only a command can set and that no command can clear. While security is set, access requests from the debug port and from the fast programming port are refused. An external ERASE pin is synchronised and timed. Once it has been held high for a parameterised number of clocks, all lock bits are cleared and the security bit is armed for clearing. The security bit then clears when the next whole-array erase completes. A factory calibration word is presented as a constant that nothing can alter. All nonvolatile state is modelled as registers.

Top module: `flash_guard`

## Requirements
- R1: After reset all lock bits and the security bit are 0, status is 3'b001 (done set, both error bits clear), busy, irq, flash_start and both grants are 0, and calib equals CAL_VALUE.
- R2: A program (opcode 1) or page erase (opcode 2) whose page lies in a locked region (region = page[8:5]) produces no flash_start, and sets the lock-error bit and the done bit. A whole-array erase (opcode 3) is aborted in the same way while any lock bit is set.
- R3: Opcode 4 sets and opcode 5 clears the lock bit whose index is the argument. An argument of 16 or more leaves the lock bits unchanged and sets the command-error bit.
- R4: ERASE qualification works on the pin after a two-flop synchroniser. The pin counts as qualified once it has been seen high for ERASE_TICKS consecutive clocks, and that clears every lock bit. A low level before that point restarts the count, so shorter pulses have no effect.
- R5: Opcode 6 with argument 0 sets the security bit. Any other argument is a command error. No opcode clears the security bit.
- R6: The security bit clears only when a whole-array erase completes after a qualified ERASE. A whole-array erase completed without a prior qualified ERASE leaves it set.
- R7: dbg_grant and prog_grant are registered copies of their requests masked by the security bit, so both stay 0 while security is set.
- R8: status is {cmd_err, lock_err, done}. A stat_rd pulse clears both error bits on the next edge, and an error raised on that same edge wins. done falls when a flash operation starts and rises when flash_done arrives.
- R9: irq is a registered copy of the lock-error bit ANDed with irq_en.
- R10: A strobe that arrives while busy sets cmd_err and has no other effect.
- R11: Opcodes 0 and 7 to 15 set cmd_err and change no state.
- R12: calib never changes: commands, the ERASE pin and reset leave it at CAL_VALUE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Opcode |
| cmd_arg | input | 8 | Region index or nonvolatile bit index |
| cmd_page | input | PAGE_W | Target page of program or page erase |
| stat_rd | input | 1 | Status read pulse, clears error bits |
| irq_en | input | 1 | Interrupt enable |
| status | output | 3 | {cmd_err, lock_err, done} |
| busy | output | 1 | Flash operation in progress |
| irq | output | 1 | Lock-error interrupt |
| flash_start | output | 1 | One-cycle start to the flash engine |
| flash_op | output | 2 | 0 program, 1 page erase, 2 whole-array erase |
| flash_page | output | PAGE_W | Page passed with flash_start |
| flash_done | input | 1 | Flash engine completion pulse |
| erase_pin | input | 1 | Asynchronous ERASE pin |
| dbg_req | input | 1 | Debug port access request |
| dbg_grant | output | 1 | Debug port access allowed |
| prog_req | input | 1 | Fast programming port request |
| prog_grant | output | 1 | Fast programming port allowed |
| lock_bits | output | REGIONS | Current lock bits |
| secure | output | 1 | Security bit |
| calib | output | CAL_W | Factory calibration word |

## Verification
The assertions assume that flash_done pulses for a single cycle and only while the block is waiting on an operation it has started. They also assume that a command strobe lasts one cycle. The bench's flash model answers each flash_start with exactly one flash_done pulse a few cycles later, and every command task drives the strobe for a single clock. The ERASE pin is driven at clock-unrelated points, but it is held steady for many cycles at a time, so the synchroniser never sees a sub-cycle pulse.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_PROG      = 4'd1,
    OP_ERASE_PG  = 4'd2,
    OP_ERASE_ALL = 4'd3,
    OP_LOCK      = 4'd4,
    OP_UNLOCK    = 4'd5,
    OP_SET_GP    = 4'd6
  } fg_op_e;

  typedef enum logic [1:0] {
    FL_PROG  = 2'd0,
    FL_PAGE  = 2'd1,
    FL_ALL   = 2'd2
  } fg_flash_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fg_state_e;
endpackage

// File: rtl/fg_erase_qual.sv
module fg_erase_qual #(
  parameter int TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic qual
);
  localparam int CW = $clog2(TICKS + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic          fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      cnt   <= '0;
      fired <= 1'b0;
      qual  <= 1'b0;
    end else begin
      s1   <= pin;
      s2   <= s1;
      qual <= 1'b0;
      if (!s2) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (!fired) begin
        if (cnt == CW'(TICKS - 1)) begin
          qual  <= 1'b1;
          fired <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fg_cmd_ctrl.sv
module fg_cmd_ctrl
  import fg_pkg::*;
#(
  parameter int REGIONS = 16,
  parameter int RSHIFT  = 5,
  parameter int ARG_W   = 8,
  parameter int PAGE_W  = $clog2(REGIONS) + RSHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [3:0]         cmd_op,
  input  logic [ARG_W-1:0]   cmd_arg,
  input  logic [PAGE_W-1:0]  cmd_page,
  input  logic               stat_rd,
  input  logic               erase_ok,
  input  logic               flash_done,
  output logic               busy,
  output logic               flash_start,
  output logic [1:0]         flash_op,
  output logic [PAGE_W-1:0]  flash_page,
  output logic [REGIONS-1:0] lock_bits,
  output logic               secure,
  output logic               armed,
  output logic               st_done,
  output logic               st_lock_err,
  output logic               st_cmd_err
);
  localparam int RW = $clog2(REGIONS);

  fg_state_e    state;
  logic         op_all;
  logic [RW-1:0] region;
  logic         arg_ok;
  logic         gp_ok;

  assign region = cmd_page[PAGE_W-1:RSHIFT];
  assign arg_ok = (cmd_arg < ARG_W'(REGIONS));
  assign gp_ok  = (cmd_arg == '0);
  assign busy   = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      lock_bits   <= '0;
      secure      <= 1'b0;
      armed       <= 1'b0;
      st_done     <= 1'b1;
      st_lock_err <= 1'b0;
      st_cmd_err  <= 1'b0;
      flash_start <= 1'b0;
      flash_op    <= FL_PROG;
      flash_page  <= '0;
      op_all      <= 1'b0;
    end else begin
      flash_start <= 1'b0;
      if (stat_rd) begin
        st_lock_err <= 1'b0;
        st_cmd_err  <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            case (cmd_op)
              OP_PROG, OP_ERASE_PG: begin
                if (lock_bits[region]) begin
                  st_lock_err <= 1'b1;
                  st_done     <= 1'b1;
                end else begin
                  flash_start <= 1'b1;
                  flash_op    <= (cmd_op == OP_PROG) ? FL_PROG : FL_PAGE;
                  flash_page  <= cmd_page;
                  op_all      <= 1'b0;
                  st_done     <= 1'b0;
                  state       <= ST_WAIT;
                end
              end
              OP_ERASE_ALL: begin
                if (|lock_bits) begin
                  st_lock_err <= 1'b1;
                  st_done     <= 1'b1;
                end else begin
                  flash_start <= 1'b1;
                  flash_op    <= FL_ALL;
                  flash_page  <= '0;
                  op_all      <= 1'b1;
                  st_done     <= 1'b0;
                  state       <= ST_WAIT;
                end
              end
              OP_LOCK, OP_UNLOCK: begin
                st_done <= 1'b1;
                if (arg_ok) lock_bits[cmd_arg[RW-1:0]] <= (cmd_op == OP_LOCK);
                else        st_cmd_err <= 1'b1;
              end
              OP_SET_GP: begin
                st_done <= 1'b1;
                if (gp_ok) secure <= 1'b1;
                else       st_cmd_err <= 1'b1;
              end
              default: begin
                st_done    <= 1'b1;
                st_cmd_err <= 1'b1;
              end
            endcase
          end
        end
        ST_WAIT: begin
          if (cmd_valid) st_cmd_err <= 1'b1;
          if (flash_done) begin
            state   <= ST_IDLE;
            st_done <= 1'b1;
            if (op_all && armed) begin
              secure <= 1'b0;
              armed  <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (erase_ok) begin
        lock_bits <= '0;
        armed     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fg_out_regs.sv
module fg_out_regs #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] req,
  input  logic             secure,
  input  logic             lock_err,
  input  logic             irq_en,
  output logic [NPORT-1:0] grant,
  output logic             irq
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) grant[p] <= 1'b0;
      else     grant[p] <= req[p] & ~secure;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= lock_err & irq_en;
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
  parameter int          REGIONS     = 16,
  parameter int          RSHIFT      = 5,
  parameter int          ARG_W       = 8,
  parameter int          CLK_HZ      = 50_000_000,
  parameter int          HOLD_MS     = 200,
  parameter int          ERASE_TICKS = (CLK_HZ / 1000) * HOLD_MS,
  parameter int          CAL_W       = 8,
  parameter logic [7:0]  CAL_VALUE   = 8'h5A,
  parameter int          PAGE_W      = $clog2(REGIONS) + RSHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [3:0]         cmd_op,
  input  logic [ARG_W-1:0]   cmd_arg,
  input  logic [PAGE_W-1:0]  cmd_page,
  input  logic               stat_rd,
  input  logic               irq_en,
  output logic [2:0]         status,
  output logic               busy,
  output logic               irq,
  output logic               flash_start,
  output logic [1:0]         flash_op,
  output logic [PAGE_W-1:0]  flash_page,
  input  logic               flash_done,
  input  logic               erase_pin,
  input  logic               dbg_req,
  output logic               dbg_grant,
  input  logic               prog_req,
  output logic               prog_grant,
  output logic [REGIONS-1:0] lock_bits,
  output logic               secure,
  output logic [CAL_W-1:0]   calib
);
  logic       erase_ok;
  logic       armed;
  logic       st_done, st_lock_err, st_cmd_err;
  logic [1:0] grant_v;

  fg_erase_qual #(.TICKS(ERASE_TICKS)) erase_i (
    .clk(clk), .rst(rst), .pin(erase_pin), .qual(erase_ok)
  );

  fg_cmd_ctrl #(
    .REGIONS(REGIONS), .RSHIFT(RSHIFT), .ARG_W(ARG_W), .PAGE_W(PAGE_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_page(cmd_page), .stat_rd(stat_rd),
    .erase_ok(erase_ok), .flash_done(flash_done), .busy(busy),
    .flash_start(flash_start), .flash_op(flash_op), .flash_page(flash_page),
    .lock_bits(lock_bits), .secure(secure), .armed(armed),
    .st_done(st_done), .st_lock_err(st_lock_err), .st_cmd_err(st_cmd_err)
  );

  fg_out_regs #(.NPORT(2)) out_i (
    .clk(clk), .rst(rst), .req({prog_req, dbg_req}), .secure(secure),
    .lock_err(st_lock_err), .irq_en(irq_en), .grant(grant_v), .irq(irq)
  );

  assign dbg_grant  = grant_v[0];
  assign prog_grant = grant_v[1];
  assign status     = {st_cmd_err, st_lock_err, st_done};

  always_ff @(posedge clk) begin
    if (rst) calib <= CAL_W'(CAL_VALUE);
    else     calib <= calib;
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int REGIONS = 16,
  parameter int RSHIFT  = 5,
  parameter int PAGE_W  = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [3:0]         cmd_op,
  input logic               busy,
  input logic [2:0]         status,
  input logic               flash_start,
  input logic [1:0]         flash_op,
  input logic [PAGE_W-1:0]  flash_page,
  input logic               flash_done,
  input logic [REGIONS-1:0] lock_bits,
  input logic               secure,
  input logic               armed,
  input logic               erase_ok,
  input logic               dbg_grant,
  input logic               prog_grant,
  input logic               irq,
  input logic               irq_en
);
  a_r2_no_locked_start: assert property (@(posedge clk) disable iff (rst)
    (flash_start && flash_op != 2'd2) |-> !lock_bits[flash_page[PAGE_W-1:RSHIFT]]);

  a_r2_all_needs_unlocked: assert property (@(posedge clk) disable iff (rst)
    (flash_start && flash_op == 2'd2) |-> (lock_bits == '0));

  a_r4_erase_clears: assert property (@(posedge clk) disable iff (rst)
    erase_ok |=> (lock_bits == '0));

  a_r5_secure_by_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(secure) |-> ($past(cmd_valid) && $past(cmd_op) == 4'd6 && !$past(busy)));

  a_r6_secure_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(secure) |-> ($past(flash_done) && $past(armed)));

  a_r7_gate: assert property (@(posedge clk) disable iff (rst)
    secure |=> (!dbg_grant && !prog_grant));

  a_r8_start_pulse: assert property (@(posedge clk) disable iff (rst)
    flash_start |=> !flash_start);

  a_r9_irq: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(status[1]) && $past(irq_en)));

  a_r10_busy_strobe: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> status[2]);
endmodule

bind flash_guard fg_checker #(
  .REGIONS(REGIONS), .RSHIFT(RSHIFT), .PAGE_W(PAGE_W)
) chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy),
  .status(status), .flash_start(flash_start), .flash_op(flash_op),
  .flash_page(flash_page), .flash_done(flash_done), .lock_bits(lock_bits),
  .secure(secure), .armed(armed), .erase_ok(erase_ok), .dbg_grant(dbg_grant),
  .prog_grant(prog_grant), .irq(irq), .irq_en(irq_en)
);

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;
  localparam int TICKS = 20;
  localparam logic [7:0] CAL = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [7:0]  cmd_arg = '0;
  logic [8:0]  cmd_page = '0;
  logic        stat_rd = 1'b0;
  logic        irq_en = 1'b0;
  logic [2:0]  status;
  logic        busy, irq, flash_start;
  logic [1:0]  flash_op;
  logic [8:0]  flash_page;
  logic        flash_done = 1'b0;
  logic        erase_pin = 1'b0;
  logic        dbg_req = 1'b0, prog_req = 1'b0;
  logic        dbg_grant, prog_grant;
  logic [15:0] lock_bits;
  logic        secure;
  logic [7:0]  calib;

  int checks = 0;
  int errors = 0;
  int starts = 0;

  always #10 clk = ~clk;

  flash_guard #(.ERASE_TICKS(TICKS), .CAL_VALUE(CAL)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_page(cmd_page), .stat_rd(stat_rd),
    .irq_en(irq_en), .status(status), .busy(busy), .irq(irq),
    .flash_start(flash_start), .flash_op(flash_op), .flash_page(flash_page),
    .flash_done(flash_done), .erase_pin(erase_pin), .dbg_req(dbg_req),
    .dbg_grant(dbg_grant), .prog_req(prog_req), .prog_grant(prog_grant),
    .lock_bits(lock_bits), .secure(secure), .calib(calib)
  );

  // flash engine model: one done pulse per start
  initial begin
    forever begin
      @(negedge clk);
      if (flash_start) begin
        starts++;
        repeat (3) @(negedge clk);
        flash_done = 1'b1;
        @(negedge clk);
        flash_done = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [3:0] op, input logic [7:0] arg, input logic [8:0] page);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cmd_page = page;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    check(lock_bits == 16'h0 && secure == 1'b0, "R1 nv state", {lock_bits, 7'd0, secure}, 0);
    check(status == 3'b001, "R1 status", status, 1);
    check(!busy && !irq && !flash_start && !dbg_grant && !prog_grant, "R1 outputs",
          {busy, irq, flash_start, dbg_grant, prog_grant}, 0);
    check(calib == CAL, "R12 calib at reset", calib, CAL);
  endtask

  task automatic t_lock_cmds();
    do_cmd(4'd4, 8'd3, '0);
    check(lock_bits == 16'h0008, "R3 set lock 3", lock_bits, 16'h0008);
    do_cmd(4'd4, 8'd16, '0);
    check(status[2] == 1'b1 && lock_bits == 16'h0008, "R3 arg out of range",
          {status, lock_bits}, {3'b101, 16'h0008});
    clear_status();
    check(status == 3'b001, "R8 cmd_err cleared by read", status, 1);
  endtask

  task automatic t_locked_abort();
    int s0 = starts;
    irq_en = 1'b1;
    do_cmd(4'd1, 8'd0, 9'(3 * 32 + 5));
    check(status[1] == 1'b1 && status[0] == 1'b1, "R2 locked program aborted", status, 3);
    check(irq == 1'b1, "R9 irq on lock error", irq, 1);
    do_cmd(4'd2, 8'd0, 9'(3 * 32 + 31));
    do_cmd(4'd3, 8'd0, '0);
    repeat (6) @(negedge clk);
    check(starts == s0, "R2 no start for locked requests", starts, s0);
    clear_status();
    check(status[1] == 1'b0, "R8 lock_err cleared by read", status, 1);
    @(negedge clk);
    check(irq == 1'b0, "R9 irq follows lock_err", irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_program_ok();
    int s0 = starts;
    do_cmd(4'd1, 8'd0, 9'(4 * 32));
    check(busy == 1'b1 && status[0] == 1'b0, "R8 done low while busy", {busy, status}, 4'b1000);
    repeat (8) @(negedge clk);
    check(!busy && status == 3'b001, "R8 done after flash_done", {busy, status}, 1);
    check(starts == s0 + 1, "R2 unlocked program started", starts, s0 + 1);
  endtask

  task automatic t_busy_strobe();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'd1; cmd_page = 9'(5 * 32);
    @(negedge clk);
    cmd_op = 4'd4; cmd_arg = 8'd9;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check(status[2] == 1'b1, "R10 strobe while busy flags error", status, 4);
    repeat (8) @(negedge clk);
    check(lock_bits[9] == 1'b0 && status[0] == 1'b1, "R10 busy strobe ignored",
          lock_bits, 16'h0008);
    clear_status();
  endtask

  task automatic t_unlock_unknown();
    do_cmd(4'd5, 8'd3, '0);
    check(lock_bits == 16'h0, "R3 clear lock 3", lock_bits, 0);
    do_cmd(4'd7, 8'd1, '0);
    check(status[2] == 1'b1 && lock_bits == 0 && !secure, "R11 unknown opcode",
          status, 5);
    clear_status();
    do_cmd(4'd0, 8'd0, '0);
    check(status[2] == 1'b1 && !busy, "R11 opcode 0", status, 5);
    clear_status();
  endtask

  task automatic t_security();
    dbg_req = 1'b1; prog_req = 1'b1;
    repeat (2) @(negedge clk);
    check(dbg_grant && prog_grant, "R7 grants while open", {dbg_grant, prog_grant}, 3);
    do_cmd(4'd6, 8'd1, '0);
    check(status[2] == 1'b1 && !secure, "R5 bad nv bit index", {status, secure}, 4'b1010);
    clear_status();
    do_cmd(4'd6, 8'd0, '0);
    check(secure == 1'b1, "R5 security set", secure, 1);
    @(negedge clk);
    check(!dbg_grant && !prog_grant, "R7 grants refused", {dbg_grant, prog_grant}, 0);
    do_cmd(4'd5, 8'd0, '0);
    do_cmd(4'd3, 8'd0, '0);
    repeat (8) @(negedge clk);
    check(secure == 1'b1, "R6 full erase alone keeps security", secure, 1);
  endtask

  task automatic t_erase_pin();
    do_cmd(4'd4, 8'd2, '0);
    for (int k = 0; k < 2; k++) begin
      erase_pin = 1'b1;
      repeat (TICKS - 3) @(negedge clk);
      erase_pin = 1'b0;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    check(lock_bits == 16'h0004, "R4 short ERASE ignored", lock_bits, 16'h0004);
    erase_pin = 1'b1;
    repeat (TICKS + 6) @(negedge clk);
    erase_pin = 1'b0;
    check(lock_bits == 16'h0, "R4 qualified ERASE clears locks", lock_bits, 0);
    check(secure == 1'b1, "R6 ERASE alone keeps security", secure, 1);
    do_cmd(4'd3, 8'd0, '0);
    repeat (8) @(negedge clk);
    check(secure == 1'b0, "R6 security cleared after full erase", secure, 0);
    @(negedge clk);
    check(dbg_grant && prog_grant, "R7 grants restored", {dbg_grant, prog_grant}, 3);
    check(calib == CAL, "R12 calib unchanged", calib, CAL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lock_cmds();
    t_locked_abort();
    t_program_ok();
    t_busy_strobe();
    t_unlock_unknown();
    t_security();
    t_erase_pin();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule